// File: doc/BRIEF.md
# Up/Down and Center-Aligned Timer Counter

This block is a programmable timer counter. It has a control register, an auto-reload register with an optional shadow buffer, a compare register, and a status register holding two sticky flags. The counter advances by one step on each clock where the run bit is set and the `tickEn` input is high. In edge-aligned mode it counts in one direction and wraps at the auto-reload value or at zero. In the three center-aligned modes it climbs from zero to the auto-reload value and then falls back to zero. An update event fires at every wrap or turnaround. A compare match sets a flag. Whether a match may set the flag depends on the mode and on the direction of the current step.

Software programs the block through a write port and a separate combinational read port, both word-wide. The block also drives a sampling strobe for input filters, with a period of one, two or four clocks. The update flag can optionally be mirrored into the top bit of the counter readback. This lets one read return both the count and the event state.

Top module: `ctr_timer`

## Requirements
- R1: During and after reset, every register reads as zero: control (address 0), status (1), count (2), reload (3) and compare (4). `updEvt`, `updFlag` and `cmpFlag` are low.
- R2: Control bit 0 is run, bit 1 is direction and bits 3:2 are the mode. In mode 00 with direction 0, each step adds one to the count. A step taken at a count equal to or above the active reload value loads 0 instead. That step pulses `updEvt` for one cycle and sets the update flag (status bit 0).
- R3: In mode 00 with direction 1, each step subtracts one. A step taken at count 0 loads the active reload value and raises the update event and the update flag.
- R4: In modes 01, 10 and 11, the count rises to the reload value and then falls to 0. Every turnaround raises the update event. While one of these modes is active, the control readback shows the direction of the current phase in bit 1 (1 = falling), and writes to bit 1 are ignored.
- R5: A step taken while the count equals the compare value sets the compare flag (status bit 1). In mode 00 and mode 11 it always sets the flag. In mode 01 it sets the flag only in a falling phase, and in mode 10 only in a rising phase.
- R6: A control write that asks for a mode other than 00, made while the stored mode is 00 and the run bit is already 1, leaves the mode at 00. The other fields of that write still take effect.
- R7: Control bit 4 enables preload. With preload off, a reload write (address 3) takes effect at once. With preload on, the value is held in a buffer and copied to the active reload value only on an update event. Reload readback returns the last value written.
- R8: Control bits 6:5 select the `sampleTick` period: 00 gives every clock, 01 every second clock, 10 every fourth clock. The value 11 acts like 00.
- R9: When control bit 7 is 1, bit 31 of the count readback carries the update flag. When bit 7 is 0, bit 31 reads as 0.
- R10: Writing 0 to a status bit clears that flag. Writing 1 leaves it unchanged. If an event and a clear arrive in the same cycle, the event wins.
- R11: No step happens when run is 0 or `tickEn` is low. A count write (address 2) loads the count, and in that cycle no step, update or compare event happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Write address |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 3 | Read address |
| regRdData | output | 32 | Combinational read data |
| tickEn | input | 1 | Count enable qualifier |
| updEvt | output | 1 | One-cycle update event pulse |
| updFlag | output | 1 | Sticky update flag |
| cmpFlag | output | 1 | Sticky compare flag |
| sampleTick | output | 1 | Filter sampling strobe |

## Verification
A wrong phase register in a center-aligned mode appears on the next step. The count moves the wrong way, and control bit 1 shows the wrong direction in the same cycle. A stale active reload value shows up at the next wrap, as a count sequence that turns around at the wrong value. A misqualified compare shows up as `cmpFlag` rising one cycle after the step on which the count equalled the compare value. The bench models every register and compares each output and one readback on every cycle, so such a fault is reported in the cycle in which it first appears at the ports.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;
  typedef enum logic [1:0] {
    MODE_EDGE     = 2'b00,
    MODE_CTR_DN   = 2'b01,
    MODE_CTR_UP   = 2'b10,
    MODE_CTR_BOTH = 2'b11
  } cntMode_e;

  typedef struct packed {
    logic step;
    logic load;
  } dpStrobe_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT    = 3'd2;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd4;

  localparam int B_RUN   = 0;
  localparam int B_DIR   = 1;
  localparam int B_MODE  = 2;
  localparam int B_PRE   = 4;
  localparam int B_DIV   = 5;
  localparam int B_REMAP = 7;
endpackage

// File: rtl/ctr_timer_dp.sv
module ctr_timer_dp
  import ctr_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] loadVal,
  input  cntMode_e         modeSel,
  input  logic             dirBit,
  input  logic [CNT_W-1:0] arrActive,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cnt,
  output logic             hwDown,
  output logic             wrapEvt,
  output logic             cmpEvt,
  output logic             updEvt
);
  logic             center;
  logic             phaseDown;
  logic             qualify;
  logic [CNT_W-1:0] nextCnt;
  logic             nextDown;

  assign center    = (modeSel != MODE_EDGE);
  assign phaseDown = center ? hwDown : dirBit;

  always_comb begin
    unique case (modeSel)
      MODE_CTR_DN: qualify = phaseDown;
      MODE_CTR_UP: qualify = !phaseDown;
      default:     qualify = 1'b1;
    endcase
  end

  assign cmpEvt = stb.step && !stb.load && (cnt == cmpVal) && qualify;

  always_comb begin
    nextCnt  = cnt;
    nextDown = center ? hwDown : dirBit;
    wrapEvt  = 1'b0;
    if (stb.load) begin
      nextCnt = loadVal;
    end else if (stb.step) begin
      if (!center) begin
        if (!dirBit) begin
          if (cnt >= arrActive) begin
            nextCnt = '0;
            wrapEvt = 1'b1;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          nextCnt = arrActive;
          wrapEvt = 1'b1;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end else if (!hwDown) begin
        if (cnt >= arrActive) begin
          nextCnt  = (cnt == '0) ? '0 : cnt - 1'b1;
          nextDown = 1'b1;
          wrapEvt  = 1'b1;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end else if (cnt == '0) begin
        nextCnt  = (arrActive == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
        nextDown = 1'b0;
        wrapEvt  = 1'b1;
      end else begin
        nextCnt = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      hwDown <= 1'b0;
      updEvt <= 1'b0;
    end else begin
      cnt    <= nextCnt;
      hwDown <= nextDown;
      updEvt <= wrapEvt;
    end
  end
endmodule

// File: rtl/ctr_timer_ctrl.sv
module ctr_timer_ctrl
  import ctr_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tickEn,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hwDown,
  input  logic              wrapEvt,
  input  logic              cmpEvt,
  output dpStrobe_t         stb,
  output cntMode_e          modeSel,
  output logic              runBit,
  output logic              dirBit,
  output logic              preBit,
  output logic              remapBit,
  output logic [1:0]        divSel,
  output logic [CNT_W-1:0]  arrActive,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              updFlag,
  output logic              cmpFlag,
  output logic              sampleTick
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             wrCtrl, wrStat, wrCnt, wrReload, wrCmp;
  logic [CNT_W-1:0] arrBuf;
  logic [1:0]       divCnt;
  logic [1:0]       reqMode;
  logic             dirShown;
  logic [DATA_W-1:0] cntWord;

  assign wrCtrl   = regWrEn && (regWrAddr == A_CTRL);
  assign wrStat   = regWrEn && (regWrAddr == A_STAT);
  assign wrCnt    = regWrEn && (regWrAddr == A_CNT);
  assign wrReload = regWrEn && (regWrAddr == A_RELOAD);
  assign wrCmp    = regWrEn && (regWrAddr == A_CMP);
  assign reqMode  = regWrData[B_MODE +: 2];

  assign stb.load = wrCnt;
  assign stb.step = runBit && tickEn && !wrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      dirBit   <= 1'b0;
      modeSel  <= MODE_EDGE;
      preBit   <= 1'b0;
      divSel   <= 2'b00;
      remapBit <= 1'b0;
    end else if (wrCtrl) begin
      runBit   <= regWrData[B_RUN];
      preBit   <= regWrData[B_PRE];
      divSel   <= regWrData[B_DIV +: 2];
      remapBit <= regWrData[B_REMAP];
      if (modeSel == MODE_EDGE) dirBit <= regWrData[B_DIR];
      if (!(runBit && modeSel == MODE_EDGE && reqMode != 2'b00))
        modeSel <= cntMode_e'(reqMode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updFlag   <= 1'b0;
      cmpFlag   <= 1'b0;
      arrBuf    <= '0;
      arrActive <= '0;
      cmpVal    <= '0;
      divCnt    <= 2'b00;
    end else begin
      divCnt <= divCnt + 2'd1;
      if (wrapEvt) updFlag <= 1'b1;
      else if (wrStat && !regWrData[0]) updFlag <= 1'b0;
      if (cmpEvt) cmpFlag <= 1'b1;
      else if (wrStat && !regWrData[1]) cmpFlag <= 1'b0;
      if (wrReload) arrBuf <= regWrData[CNT_W-1:0];
      if (wrReload && !preBit) arrActive <= regWrData[CNT_W-1:0];
      else if (wrapEvt && preBit) arrActive <= arrBuf;
      if (wrCmp) cmpVal <= regWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (divSel)
      2'b01:   sampleTick = divCnt[0];
      2'b10:   sampleTick = &divCnt;
      default: sampleTick = 1'b1;
    endcase
  end

  assign dirShown = (modeSel == MODE_EDGE) ? dirBit : hwDown;

  always_comb begin
    cntWord = {{PAD_W{1'b0}}, cnt};
    if (remapBit) cntWord[DATA_W-1] = updFlag;
  end

  always_comb begin
    regRdData = '0;
    unique case (regRdAddr)
      A_CTRL:   regRdData[7:0] = {remapBit, divSel, preBit, modeSel, dirShown, runBit};
      A_STAT:   regRdData[1:0] = {cmpFlag, updFlag};
      A_CNT:    regRdData = cntWord;
      A_RELOAD: regRdData = {{PAD_W{1'b0}}, arrBuf};
      A_CMP:    regRdData = {{PAD_W{1'b0}}, cmpVal};
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ctr_timer.sv
module ctr_timer
  import ctr_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tickEn,
  output logic              updEvt,
  output logic              updFlag,
  output logic              cmpFlag,
  output logic              sampleTick
);
  dpStrobe_t        stb;
  cntMode_e         modeSel;
  logic             runBit, dirBit, preBit, remapBit;
  logic [1:0]       divSel;
  logic [CNT_W-1:0] arrActive, cmpVal, cnt;
  logic             hwDown, wrapEvt, cmpEvt;

  ctr_timer_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .tickEn(tickEn), .cnt(cnt), .hwDown(hwDown), .wrapEvt(wrapEvt),
    .cmpEvt(cmpEvt), .stb(stb), .modeSel(modeSel), .runBit(runBit),
    .dirBit(dirBit), .preBit(preBit), .remapBit(remapBit), .divSel(divSel),
    .arrActive(arrActive), .cmpVal(cmpVal), .updFlag(updFlag),
    .cmpFlag(cmpFlag), .sampleTick(sampleTick)
  );

  ctr_timer_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(regWrData[CNT_W-1:0]),
    .modeSel(modeSel), .dirBit(dirBit), .arrActive(arrActive),
    .cmpVal(cmpVal), .cnt(cnt), .hwDown(hwDown), .wrapEvt(wrapEvt),
    .cmpEvt(cmpEvt), .updEvt(updEvt)
  );
endmodule

// File: rtl/ctr_timer_chk.sv
module ctr_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             updEvt,
  input logic             updFlag,
  input logic             cmpFlag,
  input logic             sampleTick,
  input logic             runBit,
  input logic             dirBit,
  input logic             preBit,
  input logic [1:0]       modeSel,
  input logic [1:0]       divSel,
  input logic             hwDown,
  input logic [CNT_W-1:0] arrActive,
  input logic [CNT_W-1:0] cnt
);
  // R2
  upd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |-> updFlag);

  // R2
  edge_up_wraps_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEvt && $past(modeSel) == 2'b00 && !$past(dirBit)) |-> (cnt == '0));

  // R6
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && modeSel == 2'b00) |=> (modeSel == 2'b00));

  // R7
  preload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    preBit |=> (updEvt || $stable(arrActive)));

  // R5
  mode1_down_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmpFlag) && $past(modeSel) == 2'b01) |-> $past(hwDown));

  // R8
  div2_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b10 && $past(divSel) == 2'b10 && $past(sampleTick)) |-> !sampleTick);
endmodule

bind ctr_timer ctr_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .updEvt(updEvt), .updFlag(updFlag),
  .cmpFlag(cmpFlag), .sampleTick(sampleTick), .runBit(runBit),
  .dirBit(dirBit), .preBit(preBit), .modeSel(modeSel), .divSel(divSel),
  .hwDown(hwDown), .arrActive(arrActive), .cnt(cnt)
);

// File: tb/test_ctr_timer.sv
module test_ctr_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        tickEn = 1'b0;
  logic        updEvt, updFlag, cmpFlag, sampleTick;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  ctr_timer i_ctr_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .tickEn(tickEn), .updEvt(updEvt), .updFlag(updFlag), .cmpFlag(cmpFlag),
    .sampleTick(sampleTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // model state
  logic        mRun, mDir, mPre, mRemap, mDown, mUpdF, mCmpF, mUpdEvt;
  logic [1:0]  mMode, mDiv, mDivCnt;
  logic [15:0] mCnt, mArrA, mArrB, mCmp;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      3'd0: v[7:0] = {mRemap, mDiv, mPre, mMode, (mMode != 2'b00) ? mDown : mDir, mRun};
      3'd1: v[1:0] = {mCmpF, mUpdF};
      3'd2: begin v[15:0] = mCnt; if (mRemap) v[31] = mUpdF; end
      3'd3: v[15:0] = mArrB;
      3'd4: v[15:0] = mCmp;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic modelTick();
    case (mDiv)
      2'b01:   return mDivCnt[0];
      2'b10:   return &mDivCnt;
      default: return 1'b1;
    endcase
  endfunction

  task automatic modelReset();
    {mRun, mDir, mPre, mRemap, mDown, mUpdF, mCmpF, mUpdEvt} = '0;
    mMode = '0; mDiv = '0; mDivCnt = '0;
    mCnt = '0; mArrA = '0; mArrB = '0; mCmp = '0;
  endtask

  task automatic modelEdge(input logic wr, input logic [2:0] wa, input logic [31:0] wd, input logic tk);
    logic center, step, ph, hit, wrap, nDown;
    logic [15:0] nCnt, nArrA;
    center = (mMode != 2'b00);
    step = mRun && tk && !(wr && wa == 3'd2);
    nCnt = mCnt; nDown = center ? mDown : mDir; wrap = 0; hit = 0;
    if (wr && wa == 3'd2) nCnt = wd[15:0];
    else if (step) begin
      ph = center ? mDown : mDir;
      hit = (mCnt == mCmp) && (mMode == 2'b00 || mMode == 2'b11 ||
            (mMode == 2'b01 && ph) || (mMode == 2'b10 && !ph));
      if (!center) begin
        if (!mDir) begin
          if (mCnt >= mArrA) begin nCnt = 0; wrap = 1; end else nCnt = mCnt + 1;
        end else begin
          if (mCnt == 0) begin nCnt = mArrA; wrap = 1; end else nCnt = mCnt - 1;
        end
      end else if (!mDown) begin
        if (mCnt >= mArrA) begin nCnt = (mCnt == 0) ? 16'd0 : mCnt - 1; nDown = 1; wrap = 1; end
        else nCnt = mCnt + 1;
      end else begin
        if (mCnt == 0) begin nCnt = (mArrA == 0) ? 16'd0 : 16'd1; nDown = 0; wrap = 1; end
        else nCnt = mCnt - 1;
      end
    end
    nArrA = mArrA;
    if (wr && wa == 3'd3 && !mPre) nArrA = wd[15:0];
    else if (wrap && mPre) nArrA = mArrB;
    if (wrap) mUpdF = 1; else if (wr && wa == 3'd1 && !wd[0]) mUpdF = 0;
    if (hit) mCmpF = 1; else if (wr && wa == 3'd1 && !wd[1]) mCmpF = 0;
    if (wr && wa == 3'd3) mArrB = wd[15:0];
    if (wr && wa == 3'd4) mCmp = wd[15:0];
    if (wr && wa == 3'd0) begin
      if (mMode == 2'b00) mDir = wd[1];
      if (!(mRun && mMode == 2'b00 && wd[3:2] != 2'b00)) mMode = wd[3:2];
      mRun = wd[0]; mPre = wd[4]; mDiv = wd[6:5]; mRemap = wd[7];
    end
    mArrA = nArrA; mCnt = nCnt; mDown = nDown; mUpdEvt = wrap;
    mDivCnt = mDivCnt + 2'd1;
  endtask

  // one clock: drive at negedge, model the edge, check at the next negedge
  task automatic cyc(input logic wr, input logic [2:0] wa, input logic [31:0] wd,
                     input logic tk, input logic [2:0] ra, input string tag);
    regWrEn = wr; regWrAddr = wa; regWrData = wd; tickEn = tk; regRdAddr = ra;
    @(posedge clk);
    modelEdge(wr, wa, wd, tk);
    @(negedge clk);
    check(tag, "updEvt", {31'd0, updEvt}, {31'd0, mUpdEvt});
    check(tag, "updFlag", {31'd0, updFlag}, {31'd0, mUpdF});
    check(tag, "cmpFlag", {31'd0, cmpFlag}, {31'd0, mCmpF});
    check(tag, "sampleTick", {31'd0, sampleTick}, {31'd0, modelTick()});
    check(tag, "readback", regRdData, modelRead(ra));
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, a, tag);
  endtask

  task automatic run(input int n, input logic [2:0] ra, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, 1'b1, ra, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      regRdAddr = 3'(a);
      #1;
      check("R1", "reset readback", regRdData, 32'd0);
    end
    check("R1", "reset flags", {29'd0, updEvt, updFlag, cmpFlag}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd2, "R1");

    // R11: nothing moves with run off
    run(4, 3'd2, "R11");
    // R2: edge up, reload 3
    wrReg(3'd3, 32'd3, "R2");
    wrReg(3'd0, 32'h01, "R2");
    run(10, 3'd2, "R2");
    // R11: tickEn low holds, count write loads without events
    cyc(1'b0, 3'd0, 32'd0, 1'b0, 3'd2, "R11");
    cyc(1'b1, 3'd2, 32'd3, 1'b1, 3'd2, "R11");
    cyc(1'b0, 3'd0, 32'd0, 1'b0, 3'd2, "R11");
    // R10: write ones keeps, zeros clear
    wrReg(3'd1, 32'h3, "R10");
    wrReg(3'd1, 32'h0, "R10");
    // R3: edge down
    wrReg(3'd0, 32'h03, "R3");
    run(10, 3'd2, "R3");
    // R6: mode change refused while running in edge mode
    wrReg(3'd0, 32'h0D, "R6");
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd0, "R6");
    // R4: stop, then center mode 3 with run
    wrReg(3'd0, 32'h00, "R4");
    wrReg(3'd2, 32'd0, "R4");
    wrReg(3'd0, 32'h0D, "R4");
    run(8, 3'd0, "R4");
    wrReg(3'd0, 32'h0F, "R4");
    run(8, 3'd2, "R4");
    // R5: compare qualification in each center mode
    wrReg(3'd4, 32'd2, "R5");
    for (int m = 1; m < 4; m++) begin
      wrReg(3'd0, 32'h00, "R5");
      wrReg(3'd1, 32'h0, "R5");
      wrReg(3'd0, 32'(1 | (m << 2)), "R5");
      run(5, 3'd1, "R5");
      wrReg(3'd1, 32'h1, "R5");
      run(4, 3'd1, "R5");
    end
    // R7: preload delays the new reload value to the next update
    wrReg(3'd0, 32'h00, "R7");
    wrReg(3'd2, 32'd0, "R7");
    wrReg(3'd0, 32'h11, "R7");
    wrReg(3'd3, 32'd6, "R7");
    run(14, 3'd2, "R7");
    // R8: sampling strobe periods
    wrReg(3'd0, 32'h20, "R8");
    run(6, 3'd0, "R8");
    wrReg(3'd0, 32'h40, "R8");
    run(8, 3'd0, "R8");
    wrReg(3'd0, 32'h60, "R8");
    run(4, 3'd0, "R8");
    // R9: flag mirrored into bit 31
    wrReg(3'd0, 32'h81, "R9");
    run(10, 3'd2, "R9");
    wrReg(3'd0, 32'h01, "R9");
    run(3, 3'd2, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [31:0] d;
      r = $urandom % 100;
      d = 32'($urandom % 256);
      if (r < 4) begin
        if (($urandom % 4) != 0) d[0] = 1'b1;
        cyc(1'b1, 3'd0, d, 1'($urandom % 2), 3'($urandom % 6), "R6");
      end else if (r < 7)
        cyc(1'b1, 3'd3, 32'($urandom % 10), 1'b1, 3'($urandom % 6), "R7");
      else if (r < 9)
        cyc(1'b1, 3'd4, 32'($urandom % 10), 1'b1, 3'($urandom % 6), "R5");
      else if (r < 11)
        cyc(1'b1, 3'd2, 32'($urandom % 12), 1'b1, 3'($urandom % 6), "R11");
      else if (r < 14)
        cyc(1'b1, 3'd1, 32'($urandom % 4), 1'b1, 3'($urandom % 6), "R10");
      else
        cyc(1'b0, 3'd0, 32'd0, 1'(($urandom % 4) != 0), 3'($urandom % 6), "R4");
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule